// File: doc/BRIEF.md
# Programmable PRBS and Repeating-Word Pattern Generator

This block produces a serial test stream, one bit on each cycle where its clock enable is high. It has two pattern sources. The first is a pseudo-random sequence from a two-tap feedback register whose length and tap position are set at run time. The second is a word of programmable length that is sent over and over. Both sources use the same shift register, so switching the pattern type only changes the feedback path.

To stress a link, the stream can be corrupted in two ways. A single-error request flips one outgoing bit. A rate setting flips one bit in every 10^k bits. An invert control complements the whole stream. Configuration arrives on plain input ports. A load strobe captures the pattern type, length and tap, and copies the seed or pattern word into the shift register.

A small control machine has three states. ST_IDLE is entered at reset and produces no output. ST_PRBS runs the feedback sequence and ST_REPEAT runs the repeating word. The transition LOAD_PRBS leads from any state to ST_PRBS on a load with the repeat-mode input low. LOAD_REPEAT leads from any state to ST_REPEAT on a load with that input high. No transition returns to ST_IDLE except reset.

Top module: `tpg_top`

## Requirements
- R1: After reset the block is in ST_IDLE with `dout_vld` = 0 and `dout` = 0. It produces no valid bit until the first load.
- R2: A load cycle produces no valid bit, even when `ce` is high, and latches `rep_mode`, `len_m1` and `tap`. The register length is n = `len_m1` + 1. The shift register takes `seed` masked to its low n bits.
- R3: In PRBS mode (`rep_mode` = 0) each output bit is register bit n-1. The register then shifts left by one, and bit 0 takes bit n-1 XOR bit y-1, where y = `tap`. If y is 0 or y is greater than n-1, bit 0 takes bit n-1 alone.
- R4: In repeat mode (`rep_mode` = 1) the n-bit word is sent most significant bit first, starting at bit n-1. After bit 0 it wraps back to bit n-1. `tap` is ignored.
- R5: `dout_vld` is high for exactly the cycle after each edge where `ce` was high in a running state with no load. When `ce` is low the pattern does not advance.
- R6: `invert` = 1 complements every output bit.
- R7: A one-cycle pulse on `err_one` flips exactly one output bit. If `ce` is high in the same cycle, it flips that cycle's bit; otherwise it flips the next enabled bit. Further pulses made while one is pending merge into it.
- R8: With `rate_en` = 1 and `rate_exp` = k in 1..7, the 10^k-th enabled bit is flipped, and every 10^k-th bit after it, counting from the first enabled bit after the counter restarts. The count restarts whenever `rate_en` is 0 or k changes; the cycle of a change counts no bit. k = 0 flips nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; one output bit per enabled cycle |
| load | input | 1 | Latch configuration and seed/pattern word |
| rep_mode | input | 1 | 0 = PRBS, 1 = repeating word |
| len_m1 | input | 5 | Register or word length minus one |
| tap | input | 5 | Feedback tap y of x^n + x^y + 1 |
| seed | input | 32 | Seed or pattern word |
| invert | input | 1 | Complement the output |
| err_one | input | 1 | Single-error request pulse |
| rate_en | input | 1 | Enable rate-based error insertion |
| rate_exp | input | 3 | Decade exponent k of the error rate |
| dout | output | 1 | Serial pattern bit |
| dout_vld | output | 1 | Output bit valid strobe |

## Verification
Every result is registered once. The bit selected by an enabled edge, and any flip or inversion applied to it, appear on `dout` and `dout_vld` just after that same edge. A load shows its effect as an invalid cycle right after the load edge, with the seed's top bit on the next enabled edge. The bench changes inputs on the falling edge and samples one time unit after each rising edge. Each expected bit comes from a bench-side shift model that is stepped only when a valid bit is due. Rate and exponent changes are applied with one idle cycle, so that the counter restart lines up with the bench's own bit count.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int unsigned MAX_LEN  = 32;
    localparam int unsigned LEN_W    = $clog2(MAX_LEN);
    localparam int unsigned EXP_W    = 3;
    localparam int unsigned RCNT_W   = 24;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRBS   = 2'd1,
        ST_REPEAT = 2'd2
    } tpg_state_e;

    // terminal count of the decade rate counter: 10^k - 1, zero for k = 0
    function automatic logic [RCNT_W-1:0] decade_term(input logic [EXP_W-1:0] k);
        logic [RCNT_W-1:0] acc;
        acc = 1;
        for (int i = 0; i < 7; i++) begin
            if (i < int'(k)) acc = acc * 10;
        end
        return (k == 0) ? '0 : acc - 1'b1;
    endfunction

endpackage

// File: rtl/tpg_shift_core.sv
module tpg_shift_core
    import tpg_pkg::*;
#(
    parameter int unsigned W  = MAX_LEN,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          rep_in,
    input  logic [LW-1:0] len_in,
    input  logic [LW-1:0] tap_in,
    input  logic [W-1:0]  seed_in,
    output logic          bit_out
);

    logic [W-1:0]  state_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] tap_q;
    logic          rep_q;
    logic [W-1:0]  mask_q;
    logic [W-1:0]  mask_in;
    logic          tap_bit;
    logic          fb;
    logic [W-1:0]  nxt;

    always_comb begin
        logic [W:0] wide;
        wide    = ({{W{1'b0}}, 1'b1} << ({1'b0, len_in} + 1'b1)) - 1'b1;
        mask_in = wide[W-1:0];
    end

    assign bit_out = state_q[len_q];
    assign tap_bit = (!rep_q && tap_q != '0 && tap_q <= len_q) ? state_q[tap_q - 1'b1] : 1'b0;
    assign fb      = bit_out ^ tap_bit;
    assign nxt     = ((state_q << 1) | {{(W-1){1'b0}}, fb}) & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            len_q   <= '0;
            tap_q   <= '0;
            rep_q   <= 1'b0;
            mask_q  <= '0;
        end else if (load) begin
            state_q <= seed_in & mask_in;
            len_q   <= len_in;
            tap_q   <= tap_in;
            rep_q   <= rep_in;
            mask_q  <= mask_in;
        end else if (step) begin
            state_q <= nxt;
        end
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(state_q));

    // R2
    bits_above_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q & ~mask_q) == '0);

endmodule

// File: rtl/tpg_err_gen.sv
module tpg_err_gen
    import tpg_pkg::*;
#(
    parameter int unsigned EW = EXP_W,
    parameter int unsigned CW = RCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          err_one,
    input  logic          rate_en,
    input  logic [EW-1:0] rate_exp,
    output logic          flip
);

    logic          pend_q;
    logic          pend_now;
    logic          one_fire;
    logic          rate_fire;
    logic          restart;
    logic [EW-1:0] exp_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] term;

    assign pend_now  = pend_q | err_one;
    assign one_fire  = step & pend_now;
    assign restart   = !rate_en || (rate_exp != exp_q);
    assign term      = decade_term(exp_q);
    assign rate_fire = step && !restart && (exp_q != '0) && (cnt_q == term);
    assign flip      = one_fire | rate_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            pend_q <= pend_now & ~step;
            exp_q  <= rate_exp;
            if (restart) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R7
    pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !err_one) |=> !pend_q);

    // R8
    rate_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= decade_term(exp_q));

    // R8
    rate_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_en |=> cnt_q == '0);

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int unsigned W  = MAX_LEN,
    parameter int unsigned LW = LEN_W,
    parameter int unsigned EW = EXP_W,
    parameter int unsigned CW = RCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          load,
    input  logic          rep_mode,
    input  logic [LW-1:0] len_m1,
    input  logic [LW-1:0] tap,
    input  logic [W-1:0]  seed,
    input  logic          invert,
    input  logic          err_one,
    input  logic          rate_en,
    input  logic [EW-1:0] rate_exp,
    output logic          dout,
    output logic          dout_vld
);

    tpg_state_e state_q;
    tpg_state_e state_d;
    logic       running;
    logic       step;
    logic       core_bit;
    logic       flip;

    assign running = (state_q != ST_IDLE);
    assign step    = ce && running && !load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PRBS, ST_REPEAT: begin
                if (load) state_d = rep_mode ? ST_REPEAT : ST_PRBS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= step;
            if (step) dout <= core_bit ^ invert ^ flip;
        end
    end

    tpg_shift_core #(.W(W), .LW(LW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .rep_in  (rep_mode),
        .len_in  (len_m1),
        .tap_in  (tap),
        .seed_in (seed),
        .bit_out (core_bit)
    );

    tpg_err_gen #(.EW(EW), .CW(CW)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .err_one  (err_one),
        .rate_en  (rate_en),
        .rate_exp (rate_exp),
        .flip     (flip)
    );

    // R1
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !dout_vld);

    // R2
    load_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !dout_vld);

    // R5
    vld_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(ce));

    // R5
    dout_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> $stable(dout));

endmodule

// File: tb/sim_tpg_top.sv
module sim_tpg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        load = 1'b0;
    logic        rep_mode = 1'b0;
    logic [4:0]  len_m1 = '0;
    logic [4:0]  tap = '0;
    logic [31:0] seed = '0;
    logic        invert = 1'b0;
    logic        err_one = 1'b0;
    logic        rate_en = 1'b0;
    logic [2:0]  rate_exp = '0;
    logic        dout;
    logic        dout_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_s;
    int          m_len;
    int          m_tap;
    bit          m_rep;

    always #4 clk = ~clk;

    tpg_top u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .load(load), .rep_mode(rep_mode),
        .len_m1(len_m1), .tap(tap), .seed(seed), .invert(invert), .err_one(err_one),
        .rate_en(rate_en), .rate_exp(rate_exp), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_step();
        logic [31:0] mask;
        logic        b;
        logic        fb;
        mask = (m_len == 31) ? 32'hFFFF_FFFF : ((32'd1 << (m_len + 1)) - 1);
        b    = m_s[m_len];
        fb   = b;
        if (!m_rep && m_tap != 0 && m_tap <= m_len) fb = b ^ m_s[m_tap-1];
        m_s  = ((m_s << 1) | {31'd0, fb}) & mask;
        return b;
    endfunction

    task automatic do_load(input bit rep, input int len, input int tp, input logic [31:0] sd);
        @(negedge clk);
        rep_mode = rep; len_m1 = 5'(len - 1); tap = 5'(tp); seed = sd;
        load = 1'b1; ce = 1'b1;
        @(posedge clk); #1;
        check("R2 load cycle no vld", {1'b0, dout_vld}, 2'b00);
        @(negedge clk);
        load = 1'b0; ce = 1'b0;
        m_rep = rep; m_len = len - 1; m_tap = tp;
        m_s = (len == 32) ? sd : (sd & ((32'd1 << len) - 1));
    endtask

    task automatic one_bit(input string req, input logic flip_exp);
        logic e;
        @(negedge clk);
        ce = 1'b1;
        @(posedge clk); #1;
        e = model_step() ^ invert ^ flip_exp;
        check(req, {dout_vld, dout}, {1'b1, e});
        @(negedge clk);
        ce = 1'b0; err_one = 1'b0;
    endtask

    task automatic bits_plain(input string req, input int n);
        for (int i = 0; i < n; i++) one_bit(req, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {dout_vld, dout}, 2'b00);
        @(negedge clk); ce = 1'b1;
        @(posedge clk); #1;
        check("R1 idle with ce no vld", {1'b0, dout_vld}, 2'b00);
        @(negedge clk); ce = 1'b0;
    endtask

    task automatic t_prbs();
        do_load(1'b0, 7, 6, 32'h7F);
        bits_plain("R3 prbs7", 140);
        do_load(1'b0, 32, 22, 32'hDEAD_BEEF);
        bits_plain("R3 prbs32", 80);
        do_load(1'b0, 4, 0, 32'hFFFF_FFF9);
        bits_plain("R3 tap zero rotate", 10);
    endtask

    task automatic t_repeat();
        do_load(1'b1, 5, 3, 32'hFFFF_FF16);
        bits_plain("R4 repeat n5", 12);
        do_load(1'b1, 1, 0, 32'h1);
        bits_plain("R4 repeat n1", 3);
        do_load(1'b1, 32, 5, 32'h8000_0001);
        bits_plain("R4 repeat n32", 34);
    endtask

    task automatic t_throttle();
        do_load(1'b0, 9, 5, 32'h1A5);
        one_bit("R5 bit before gap", 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check("R5 ce low no vld", {1'b0, dout_vld}, 2'b00);
        end
        bits_plain("R5 resume no skip", 8);
    endtask

    task automatic t_invert();
        do_load(1'b0, 7, 6, 32'h55);
        invert = 1'b1;
        bits_plain("R6 inverted", 10);
        invert = 1'b0;
        bits_plain("R6 normal again", 3);
    endtask

    task automatic t_single();
        do_load(1'b0, 11, 9, 32'h3C3);
        bits_plain("R7 pre", 2);
        @(negedge clk); err_one = 1'b1;
        one_bit("R7 same cycle flip", 1'b1);
        one_bit("R7 only one flip", 1'b0);
        @(negedge clk); err_one = 1'b1;
        @(negedge clk); err_one = 1'b0;
        @(negedge clk); err_one = 1'b1;
        @(negedge clk); err_one = 1'b0;
        one_bit("R7 pending flip", 1'b1);
        one_bit("R7 merged no second", 1'b0);
        one_bit("R7 merged no third", 1'b0);
    endtask

    task automatic rate_run(input string req, input int period, input int n);
        for (int i = 1; i <= n; i++) one_bit(req, (period > 0 && (i % period) == 0));
    endtask

    task automatic t_rate();
        do_load(1'b0, 15, 14, 32'h1234);
        @(negedge clk); rate_en = 1'b1; rate_exp = 3'd1;
        @(negedge clk);
        rate_run("R8 rate k1", 10, 35);
        @(negedge clk); rate_exp = 3'd2;
        @(negedge clk);
        rate_run("R8 rate k2 restart", 100, 205);
        @(negedge clk); rate_exp = 3'd0;
        @(negedge clk);
        rate_run("R8 k0 no flips", 0, 25);
        @(negedge clk); rate_en = 1'b0; rate_exp = 3'd1;
        @(negedge clk);
        rate_run("R8 disabled no flips", 0, 15);
        @(negedge clk); rate_en = 1'b1;
        @(negedge clk);
        rate_run("R8 reenable restart", 10, 22);
        @(negedge clk); rate_en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_prbs();
        t_repeat();
        t_throttle();
        t_invert();
        t_single();
        t_rate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule